// File: doc/BRIEF.md
# Chained Decimal Digit Adder

This block adds two packed binary-coded-decimal numbers plus an incoming carry and returns a packed decimal sum and an outgoing decimal carry. Each digit stage works in two steps. First it forms the plain 5-bit binary total of its two nibbles and its carry. Then it checks whether that total has left the decimal range. If it has, the stage adds six to the low four bits, which wraps the digit back into 0 to 9. The same out-of-range condition is passed to the next stage as its decimal carry.

`NDIG` stages are rippled together, with the least significant digit in bits [3:0]. A registered wrapper captures each result when `in_valid` is high. It raises `out_valid` one clock later and holds the result registers while no new operands arrive. If any operand nibble is not a legal decimal code (above 9), a flag is raised. The sum is still formed with the same per-digit rule, but the result should then be treated as invalid.

Top module: `dadd_pipe`

## Requirements
- R1: When every operand nibble is in 0..9, each result nibble is in 0..9 and equals the decimal sum digit at that position.
- R2: The carry out of a digit stage is 1 exactly when its binary total (a + b + carry-in) is 10 or more, and then the digit is that total minus 10.
- R3: Correction example: 7 + 8 with no carry gives digit 0101 and decimal carry 1.
- R4: Correction example: 5 + 9 with no carry gives digit 0100 and decimal carry 1.
- R5: With carry-in, the largest single-digit case 9 + 9 + 1 gives digit 1001 and carry 1.
- R6: Digits ripple: nibble k (bits 4k+3..4k) receives the carry of nibble k-1, nibble 0 receives `carry_in`, and `carry_out` is the carry of the top nibble, so the packed result is the full decimal sum modulo 10^NDIG.
- R7: `bad_code` is 1 when any operand nibble is above 9. The sum is still produced per digit: total t = a + b + cin, and if t > 9 the digit is (t + 6) mod 16 with carry 1; otherwise the digit is t with carry 0.
- R8: Results, `carry_out` and `bad_code` appear on the outputs one clock after the edge that samples `in_valid` = 1, together with `out_valid` = 1. While `in_valid` is 0, `out_valid` drops one clock later and all result outputs hold.
- R9: During and right after reset, `out_valid`, `sum_digits`, `carry_out` and `bad_code` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operands present this cycle |
| a_digits | input | 4*NDIG | First packed decimal operand, digit 0 in bits [3:0] |
| b_digits | input | 4*NDIG | Second packed decimal operand |
| carry_in | input | 1 | Decimal carry into digit 0 |
| out_valid | output | 1 | Registered result is new this cycle |
| sum_digits | output | 4*NDIG | Registered packed decimal sum |
| carry_out | output | 1 | Registered decimal carry out of the top digit |
| bad_code | output | 1 | Registered flag: some operand nibble exceeded 9 |

## Verification
Errors in the correction or carry condition show up at the outputs in the cycle after the operands are sampled. Depending on the fault, a result nibble reads 10..15, or a carry is lost or spurious so that the next digit up is off by one. Any stage can hide a wrong carry while its neighbour's operands are small, so the sum is checked over all single-digit combinations and also across carry chains of full nines. A register fault appears as `out_valid` at the wrong cycle, or as result outputs that move while `in_valid` is low.

// File: rtl/dadd_pkg.sv
package dadd_pkg;
  localparam int DW = 4;
  typedef logic [DW-1:0] nibble_t;

  // Plain binary total of two nibbles and a carry.
  function automatic logic [DW:0] raw_add(nibble_t a, nibble_t b, logic c);
    return {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, c};
  endfunction

  // Total left the decimal range: binary carry, or 1x1x / 11xx pattern.
  function automatic logic needs_fix(logic [DW:0] r);
    return r[4] | (r[3] & r[2]) | (r[3] & r[1]);
  endfunction

  // Wrap an over-range nibble back by adding six.
  function automatic nibble_t apply_fix(nibble_t s, logic f);
    return f ? s + nibble_t'(6) : s;
  endfunction

  // Nibble is not a legal decimal code.
  function automatic logic not_decimal(nibble_t d);
    return d[3] & (d[2] | d[1]);
  endfunction
endpackage

// File: rtl/dadd_digit.sv
module dadd_digit
  import dadd_pkg::*;
(
  input  nibble_t    a,
  input  nibble_t    b,
  input  logic       cin,
  output nibble_t    sum,
  output logic       cout,
  output logic       bad,
  output logic [4:0] raw_total,
  output logic       fix_hit
);
  always_comb begin
    raw_total = raw_add(a, b, cin);
    fix_hit   = needs_fix(raw_total);
    sum       = apply_fix(raw_total[3:0], fix_hit);
    cout      = fix_hit;
    bad       = not_decimal(a) | not_decimal(b);
  end

  always_comb begin
    if (!bad) begin
      AST_DIGIT_RANGE: assert (sum <= 4'd9); // R1
      AST_DIGIT_BALANCE: assert ({1'b0, sum} + (cout ? 5'd10 : 5'd0) == raw_total); // R2
    end
  end
endmodule

// File: rtl/dadd_chain.sv
module dadd_chain
  import dadd_pkg::*;
#(
  parameter int NDIG = 3,
  localparam int W = NDIG * DW
) (
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         cin,
  output logic [W-1:0] sum_out,
  output logic         cout,
  output logic         bad_any
);
  logic [NDIG:0]   carry_link;
  logic [NDIG-1:0] bad_vec;
  logic [NDIG-1:0] fix_vec;

  assign carry_link[0] = cin;

  for (genvar k = 0; k < NDIG; k++) begin : g_dig
    logic [4:0] raw_k;
    dadd_digit u_dig (
      .a        (a_in[k*DW +: DW]),
      .b        (b_in[k*DW +: DW]),
      .cin      (carry_link[k]),
      .sum      (sum_out[k*DW +: DW]),
      .cout     (carry_link[k+1]),
      .bad      (bad_vec[k]),
      .raw_total(raw_k),
      .fix_hit  (fix_vec[k])
    );
  end

  assign cout    = carry_link[NDIG];
  assign bad_any = |bad_vec;

  always_comb begin
    if (!bad_any) begin
      AST_CHAIN_TOP_CARRY: assert (cout == (sum_out[W-1 -: DW] < b_in[W-1 -: DW] ||
        (sum_out[W-1 -: DW] == b_in[W-1 -: DW] && (a_in[W-1 -: DW] != 0 || carry_link[NDIG-1])))); // R6
    end
  end
endmodule

// File: rtl/dadd_pipe.sv
module dadd_pipe
  import dadd_pkg::*;
#(
  parameter int NDIG = 3,
  localparam int W = NDIG * DW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] a_digits,
  input  logic [W-1:0] b_digits,
  input  logic         carry_in,
  output logic         out_valid,
  output logic [W-1:0] sum_digits,
  output logic         carry_out,
  output logic         bad_code
);
  logic [W-1:0] comb_sum;
  logic         comb_cout;
  logic         comb_bad;

  dadd_chain #(.NDIG(NDIG)) u_chain (
    .a_in   (a_digits),
    .b_in   (b_digits),
    .cin    (carry_in),
    .sum_out(comb_sum),
    .cout   (comb_cout),
    .bad_any(comb_bad)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      sum_digits <= '0;
      carry_out  <= 1'b0;
      bad_code   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        sum_digits <= comb_sum;
        carry_out  <= comb_cout;
        bad_code   <= comb_bad;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R8
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R8
  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(sum_digits) && $stable(carry_out) && $stable(bad_code))); // R8

  for (genvar k = 0; k < NDIG; k++) begin : g_chk
    AST_OUT_DECIMAL: assert property (@(posedge clk) disable iff (!rst_n)
      !bad_code |-> sum_digits[k*DW +: DW] <= 4'd9); // R1
  end
endmodule

// File: tb/tb_dadd_pipe.sv
module tb_dadd_pipe;
  localparam int NDIG = 3;
  localparam int W = NDIG * 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [W-1:0] a_digits = '0;
  logic [W-1:0] b_digits = '0;
  logic         carry_in = 1'b0;
  logic         out_valid;
  logic [W-1:0] sum_digits;
  logic         carry_out;
  logic         bad_code;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dadd_pipe #(.NDIG(NDIG)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .a_digits(a_digits), .b_digits(b_digits), .carry_in(carry_in),
    .out_valid(out_valid), .sum_digits(sum_digits),
    .carry_out(carry_out), .bad_code(bad_code)
  );

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] to_bcd(int v);
    logic [W-1:0] r = '0;
    for (int k = 0; k < NDIG; k++) begin
      r[k*4 +: 4] = 4'(v % 10);
      v = v / 10;
    end
    return r;
  endfunction

  function automatic int pow10n();
    int p = 1;
    for (int k = 0; k < NDIG; k++) p = p * 10;
    return p;
  endfunction

  // Per-nibble model for illegal codes (R7).
  function automatic logic [W:0] nibble_model(logic [W-1:0] a, logic [W-1:0] b, logic c);
    logic [W-1:0] s = '0;
    int cc = c;
    for (int k = 0; k < NDIG; k++) begin
      int t = int'(a[k*4 +: 4]) + int'(b[k*4 +: 4]) + cc;
      if (t > 9) begin s[k*4 +: 4] = 4'((t + 6) % 16); cc = 1; end
      else begin s[k*4 +: 4] = 4'(t); cc = 0; end
    end
    return {cc[0], s};
  endfunction

  task automatic apply(logic [W-1:0] a, logic [W-1:0] b, logic c);
    @(negedge clk);
    a_digits = a; b_digits = b; carry_in = c; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_dec(string req, int a, int b, logic c);
    int tot = a + b + int'(c);
    apply(to_bcd(a), to_bcd(b), c);
    check({req, " valid"}, out_valid, 1);
    check({req, " sum"}, sum_digits, to_bcd(tot));
    check({req, " carry"}, carry_out, (tot >= pow10n()) ? 1 : 0);
    check({req, " flag"}, bad_code, 0);
  endtask

  task automatic test_reset();
    check("R9 valid", out_valid, 0);
    check("R9 sum", sum_digits, 0);
    check("R9 carry", carry_out, 0);
    check("R9 flag", bad_code, 0);
  endtask

  task automatic test_examples();
    apply(12'h007, 12'h008, 1'b0);
    check("R3 digit", sum_digits[3:0], 4'b0101);
    check("R3 next digit", sum_digits[7:4], 1);
    apply(12'h005, 12'h009, 1'b0);
    check("R4 digit", sum_digits[3:0], 4'b0100);
    check("R4 next digit", sum_digits[7:4], 1);
    apply(12'h009, 12'h009, 1'b1);
    check("R5 digit", sum_digits[3:0], 4'b1001);
    check("R5 next digit", sum_digits[7:4], 1);
  endtask

  task automatic test_all_digits();
    for (int a = 0; a < 10; a++)
      for (int b = 0; b < 10; b++)
        for (int c = 0; c < 2; c++)
          run_dec("R1 R2", a, b, c[0]);
  endtask

  task automatic test_ripple();
    run_dec("R6 full wrap", 999, 0, 1'b1);
    run_dec("R6 carry chain", 499, 501, 1'b0);
    run_dec("R6 no carry", 123, 456, 1'b1);
    run_dec("R6 top carry", 999, 999, 1'b1);
    run_dec("R6 middle", 90, 10, 1'b0);
  endtask

  task automatic test_bad();
    logic [W:0] m;
    m = nibble_model(12'h0F0, 12'h0F0, 1'b0);
    apply(12'h0F0, 12'h0F0, 1'b0);
    check("R7 flag", bad_code, 1);
    check("R7 sum", sum_digits, m[W-1:0]);
    check("R7 carry", carry_out, m[W]);
    m = nibble_model(12'h000, 12'h00A, 1'b0);
    apply(12'h000, 12'h00A, 1'b0);
    check("R7 flag b", bad_code, 1);
    check("R7 sum b", sum_digits, m[W-1:0]);
    run_dec("R7 flag clears", 1, 1, 1'b0);
  endtask

  task automatic test_hold();
    apply(to_bcd(345), to_bcd(210), 1'b0);
    @(negedge clk);
    a_digits = 12'hFFF; b_digits = 12'h999; carry_in = 1'b1;
    check("R8 valid drops", out_valid, 0);
    repeat (3) @(negedge clk);
    check("R8 hold sum", sum_digits, to_bcd(555));
    check("R8 hold flag", bad_code, 0);
    check("R8 hold carry", carry_out, 0);
    check("R8 still low", out_valid, 0);
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_examples();
    test_all_digits();
    test_ripple();
    test_bad();
    test_hold();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule